// File: doc/BRIEF.md
# Serial Management Register Responder

This block answers a serial management bus that software drives one bit at a time. Software toggles a management clock input and a data-out input. A separate direction input selects read mode. The block returns read data on a single data-in output. It models a bank of thirty-two 16-bit transceiver configuration registers. The bank sits at a single station address. Every register has a fixed power-up value and a constant mask that marks which of its bits may be written.

All inputs are sampled on the system clock. The block acts only when the sampled management clock goes from low to high. On each such edge it shifts one bit into a 32-bit word and advances a bit counter. At fixed counts it decodes the word:

- After sixteen bits it recognises a read request and loads the addressed register into the word. The value is then shifted out.
- After thirty-two bits it recognises a write request and merges the data into the register through its mask.

A word of all ones (the preamble) puts the counter back to zero. This is how software resynchronises before every frame.

Top module: `mii_mgmt_resp`

## Requirements
- R1: After reset, `mdi_o` is 0 and the registers hold 0x3100 (index 0), 0xF02C (1), 0x7810 (2), 0x0501 (4), 0x4181 (5), 0x0003 (16) and 0x0001 (18); every other index holds 0.
- R2: Only a low-to-high change of the sampled `mdc_i` has any effect. Keeping `mdc_i` high or low for any number of system clocks leaves `mdi_o`, the counter and the word unchanged.
- R3: On each rising management edge, the counter is incremented and the word shifts left by one bit. The new bit 0 is `mdo_i` when the incremented count is below 16 or when `rd_mode_i` is 0. Otherwise, in read mode at a count of 16 or more, the new bit 0 is 0.
- R4: On a rising edge where the incremented count is 16 or more and `rd_mode_i` is 1, `mdi_o` takes bit 15 of the shifted word. On any other rising edge, `mdi_o` keeps its value.
- R5: If the shifted word is all ones, the counter returns to 0. So 32 or more consecutive 1 bits resynchronise the frame, whatever came before.
- R6: At count 16 the word is decoded as bits 15:12 = opcode, 11:7 = station address and 6:2 = register index, with the first bit sent being the most significant. Opcode 4'b0110 replaces the word with the register value, zero-extended. As a result, after edges 17 to 31 of a read, `mdi_o` shows register bits 14 down to 0. After edge 32 it shows 0.
- R7: At count 32 the word is decoded as bits 31:28 = opcode, 27:23 = station address, 22:18 = register index and 15:0 = data. Opcode 4'b0101 performs a write.
- R8: Only station address 1 responds. Reads at any other address return all zeros, and writes to them leave every register unchanged.
- R9: A write stores (old AND NOT mask) OR (data AND mask). The mask is:
  - 0xFFFF for indices 1, 2, 3, 5, 6 and 18 to 25
  - 0xC01F for index 4
  - 0x0FFF for index 16
  - 0 for every other index

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc_i | input | 1 | Management clock level as written by software |
| mdo_i | input | 1 | Management data driven toward the responder |
| rd_mode_i | input | 1 | 1 selects read direction, 0 selects write direction |
| mdi_o | output | 1 | Management data returned to software |

## Verification
The bound checker watches several properties on every system clock:

- Nothing moves without a rising management edge.
- `mdi_o` stays put while the direction input selects write.
- A write strobe is always followed by a count of 32.
- The register bank changes only on a write addressed to station 1.
- Bits outside each register's mask never change.

Only the bench's frame scenarios can show the rest:

- The actual bit-serial read-out order.
- The merged values after masked writes.
- That `mdo_i` is ignored during a read's data phase.
- That a preamble recovers framing after stray bits.

// File: rtl/mii_resp_pkg.sv
// Package: constants and per-register tables for the serial management
// responder. Assumes a fixed 32 x 16-bit register bank; the tables are
// computed by functions so no literal list exceeds a few entries.
package mii_resp_pkg;

    localparam int NREG     = 32;
    localparam int DW       = 16;
    localparam int AW       = $clog2(NREG);
    localparam int WORD_W   = 32;
    localparam int OP_W     = 4;
    localparam logic [OP_W-1:0] OP_READ  = 4'b0110;
    localparam logic [OP_W-1:0] OP_WRITE = 4'b0101;

    // Power-up value of register idx
    function automatic logic [DW-1:0] reg_default(input int idx);
        case (idx)
            0:       return 16'h3100;
            1:       return 16'hF02C;
            2:       return 16'h7810;
            4:       return 16'h0501;
            5:       return 16'h4181;
            16:      return 16'h0003;
            18:      return 16'h0001;
            default: return '0;
        endcase
    endfunction

    // Writable-bit mask of register idx
    function automatic logic [DW-1:0] reg_wmask(input int idx);
        if (idx == 4)                              return 16'hC01F;
        if (idx == 16)                             return 16'h0FFF;
        if ((idx >= 1 && idx <= 3) || idx == 5 || idx == 6) return 16'hFFFF;
        if (idx >= 18 && idx <= 25)                return 16'hFFFF;
        return '0;
    endfunction

    // All masks concatenated, register 0 in the low slice
    function automatic logic [NREG*DW-1:0] mask_flat();
        logic [NREG*DW-1:0] m;
        m = '0;
        for (int i = 0; i < NREG; i++) m[i*DW +: DW] = reg_wmask(i);
        return m;
    endfunction

endpackage

// File: rtl/mii_mdc_edge.sv
// Module: detects a low-to-high change of the software-driven management
// clock. Assumes mdc_i is already synchronous to clk (written by software
// through a register), so no synchroniser stages are added.
module mii_mdc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    output logic rise_o
);

    logic mdc_q;

    // Remember the previous clock sample
    always_ff @(posedge clk) begin
        if (!rst_n) mdc_q <= 1'b0;
        else        mdc_q <= mdc_i;
    end

    assign rise_o = mdc_i & ~mdc_q;

endmodule

// File: rtl/mii_frame_shift.sv
// Module: the shifting-word frame decoder. On each management rising edge
// it advances a saturating bit counter, shifts one bit into a 32-bit word,
// drives the return bit in read mode, decodes a read at count 16 and a
// write at count 32. Assumes the register read data arrives combinationally
// from the address it presents.
module mii_frame_shift
    import mii_resp_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              mdo_i,
    input  logic              rd_mode_i,
    input  logic [DW-1:0]     rd_data_i,
    output logic [AW-1:0]     rd_phy_o,
    output logic [AW-1:0]     rd_reg_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_phy_o,
    output logic [AW-1:0]     wr_reg_o,
    output logic [DW-1:0]     wr_data_o,
    output logic              mdi_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_RD  = CNT_W'(16);
    localparam logic [CNT_W-1:0] CNT_WR  = CNT_W'(32);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_sh;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic              shift_bit;
    logic              all_ones;
    logic              rd_hit;

    // Next count, shifted word and field decodes
    always_comb begin
        cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        shift_bit = mdo_i & ((cnt_inc < CNT_RD) | ~rd_mode_i);
        word_sh   = {word_q[WORD_W-2:0], shift_bit};
        all_ones  = &word_sh;
        rd_hit    = (cnt_inc == CNT_RD) && (word_sh[15:12] == OP_READ);
        rd_phy_o  = word_sh[11:7];
        rd_reg_o  = word_sh[6:2];
        wr_phy_o  = word_sh[27:23];
        wr_reg_o  = word_sh[22:18];
        wr_data_o = word_sh[15:0];
        wr_en_o   = rise_i && !all_ones && (cnt_inc == CNT_WR)
                    && (word_sh[31:28] == OP_WRITE);
    end

    // Counter, word and return bit update on management rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            mdi_o  <= 1'b0;
        end else if (rise_i) begin
            if (cnt_inc >= CNT_RD && rd_mode_i) mdi_o <= word_sh[15];
            if (all_ones) begin
                cnt_q  <= '0;
                word_q <= word_sh;
            end else begin
                cnt_q  <= cnt_inc;
                word_q <= rd_hit ? {{(WORD_W-DW){1'b0}}, rd_data_i} : word_sh;
            end
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/mii_reg_bank.sv
// Module: the register bank. Each register resets to its table value and
// merges write data through its constant mask; bits outside the mask are
// constants after reset. Assumes wr_en_i is already qualified by address.
module mii_reg_bank
    import mii_resp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_idx_i,
    input  logic [DW-1:0]      wr_data_i,
    output logic [NREG*DW-1:0] regs_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] DEF  = reg_default(g);
        localparam logic [DW-1:0] MASK = reg_wmask(g);
        logic [DW-1:0] r;

        // Masked write merge for register g
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= DEF;
            else if (wr_en_i && wr_idx_i == AW'(g))
                r <= (r & ~MASK) | (wr_data_i & MASK);
        end

        assign regs_o[g*DW +: DW] = r;
    end

endmodule

// File: rtl/mii_mgmt_resp.sv
// Module: top of the serial management responder. Joins edge detection,
// the frame decoder and the register bank, and applies the station-address
// match for both reads and writes. Assumes all inputs are synchronous.
module mii_mgmt_resp
    import mii_resp_pkg::*;
#(
    parameter int PHY_ADDR = 1,
    parameter int CNT_W    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdo_i,
    input  logic rd_mode_i,
    output logic mdi_o
);

    logic               mdc_rise;
    logic [AW-1:0]      rd_phy, rd_reg, wr_phy, wr_reg;
    logic [DW-1:0]      rd_data, wr_data;
    logic               wr_en, wr_hit;
    logic [CNT_W-1:0]   bit_cnt;
    logic [NREG*DW-1:0] reg_flat;

    mii_mdc_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .rise_o (mdc_rise)
    );

    mii_frame_shift #(.CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (mdc_rise),
        .mdo_i     (mdo_i),
        .rd_mode_i (rd_mode_i),
        .rd_data_i (rd_data),
        .rd_phy_o  (rd_phy),
        .rd_reg_o  (rd_reg),
        .wr_en_o   (wr_en),
        .wr_phy_o  (wr_phy),
        .wr_reg_o  (wr_reg),
        .wr_data_o (wr_data),
        .mdi_o     (mdi_o),
        .cnt_o     (bit_cnt)
    );

    // Station match: foreign addresses read zero and never write
    always_comb begin
        rd_data = '0;
        if (rd_phy == AW'(PHY_ADDR)) rd_data = reg_flat[{rd_reg, 4'b0000} +: DW];
        wr_hit = wr_en && (wr_phy == AW'(PHY_ADDR));
    end

    mii_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_hit),
        .wr_idx_i  (wr_reg),
        .wr_data_i (wr_data),
        .regs_o    (reg_flat)
    );

endmodule

// File: rtl/mii_mgmt_resp_chk.sv
// Module: checker bound to the responder top. Observes the edge strobe,
// counter, write strobes and register bank over time.
module mii_mgmt_resp_chk
    import mii_resp_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic               rd_mode,
    input  logic               mdi,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               wr_en,
    input  logic               wr_hit,
    input  logic [NREG*DW-1:0] regs
);

    localparam logic [NREG*DW-1:0] RO_BITS = ~mask_flat();

    // R2: without a management rising edge nothing advances
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> ($stable(mdi) && $stable(cnt)));

    // R4: the return bit only moves in read direction
    p_write_dir_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !rd_mode) |=> $stable(mdi));

    // R7: a write strobe coincides with the 32nd bit
    p_write_at_32_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == CNT_W'(32)));

    // R8: the bank changes only on a write to the own station
    p_foreign_phy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(regs));

    // R9: bits outside each mask never change
    p_ro_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> ((regs & RO_BITS) == ($past(regs) & RO_BITS)));

endmodule

bind mii_mgmt_resp mii_mgmt_resp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (mdc_rise),
    .rd_mode (rd_mode_i),
    .mdi     (mdi_o),
    .cnt     (bit_cnt),
    .wr_en   (wr_en),
    .wr_hit  (wr_hit),
    .regs    (reg_flat)
);

// File: tb/mii_mgmt_resp_tb.sv
module mii_mgmt_resp_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic mdo = 1'b0;
    logic rd_mode = 1'b0;
    logic mdi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic  q_exp[$];
    string q_tag[$];
    event  ev_smp;

    always #5 clk = ~clk;

    mii_mgmt_resp u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_i     (mdc),
        .mdo_i     (mdo),
        .rd_mode_i (rd_mode),
        .mdi_o     (mdi)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: mdi actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected bit per sample event
    always @(ev_smp) begin
        if (q_exp.size() > 0) check(mdi, q_exp.pop_front(), q_tag.pop_front());
    end

    // One management bit: low half, rising edge, optional extra high time
    task automatic bit_out(input logic d, input logic rd, input int hold);
        @(negedge clk); mdo = d; rd_mode = rd; mdc = 1'b0;
        @(negedge clk); mdc = 1'b1;
        repeat (1 + hold) @(negedge clk);
    endtask

    task automatic preamble();
        repeat (32) bit_out(1'b1, 1'b0, 0);
    endtask

    task automatic write_frame(input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] data);
        logic [31:0] f;
        f = {4'b0101, phy, rg, 2'b10, data};
        preamble();
        for (int i = 31; i >= 0; i--) bit_out(f[i], 1'b0, 0);
    endtask

    // Driver: read frame, pushing the expected return bit after each edge
    task automatic read_frame(input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] exp, input string tag,
                              input logic junk, input int hold);
        logic [15:0] f;
        f = {4'b0110, phy, rg, 2'b00};
        preamble();
        for (int i = 15; i >= 0; i--) bit_out(f[i], 1'b0, 0);
        for (int k = 1; k <= 16; k++) begin
            bit_out(junk, 1'b1, (k == 1) ? hold : 0);
            q_exp.push_back((k <= 15) ? exp[15-k] : 1'b0);
            q_tag.push_back(tag);
            -> ev_smp;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mdi, 1'b0, "R1 reset mdi");

        // R1 / R6: defaults read back bit-serially
        read_frame(5'd1, 5'd0,  16'h3100, "R1 R6 reg0",  1'b0, 0);
        read_frame(5'd1, 5'd1,  16'hF02C, "R1 R6 reg1",  1'b0, 0);
        read_frame(5'd1, 5'd2,  16'h7810, "R1 R6 reg2",  1'b0, 0);
        read_frame(5'd1, 5'd3,  16'h0000, "R1 reg3",     1'b0, 0);
        read_frame(5'd1, 5'd4,  16'h0501, "R1 reg4",     1'b0, 0);
        read_frame(5'd1, 5'd5,  16'h4181, "R1 reg5",     1'b0, 0);
        read_frame(5'd1, 5'd16, 16'h0003, "R1 reg16",    1'b0, 0);
        read_frame(5'd1, 5'd18, 16'h0001, "R1 reg18",    1'b0, 0);

        // R7: full write then read back
        write_frame(5'd1, 5'd1, 16'h1234);
        read_frame(5'd1, 5'd1, 16'h1234, "R7 write reg1", 1'b0, 0);

        // R9: masked merges
        write_frame(5'd1, 5'd0, 16'hFFFF);
        read_frame(5'd1, 5'd0, 16'h3100, "R9 reg0 read-only", 1'b0, 0);
        write_frame(5'd1, 5'd4, 16'hFFFF);
        read_frame(5'd1, 5'd4, 16'hC51F, "R9 reg4 mask C01F", 1'b0, 0);
        write_frame(5'd1, 5'd16, 16'hABCD);
        read_frame(5'd1, 5'd16, 16'h0BCD, "R9 reg16 mask 0FFF", 1'b0, 0);

        // R8: foreign station ignored and reads zero
        write_frame(5'd2, 5'd1, 16'hFFFF);
        read_frame(5'd1, 5'd1, 16'h1234, "R8 foreign write ignored", 1'b0, 0);
        read_frame(5'd3, 5'd1, 16'h0000, "R8 foreign read zero", 1'b0, 0);

        // R3 / R2: mdo ignored in read data phase; long high MDC holds
        read_frame(5'd1, 5'd2, 16'h7810, "R3 R2 junk mdo and hold", 1'b1, 7);

        // R5: stray bits then preamble resynchronises
        bit_out(1'b0, 1'b0, 0); bit_out(1'b1, 1'b0, 0);
        bit_out(1'b1, 1'b0, 0); bit_out(1'b0, 1'b0, 0);
        bit_out(1'b1, 1'b0, 0);
        read_frame(5'd1, 5'd5, 16'h4181, "R5 resync", 1'b0, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule